// File: doc/BRIEF.md
# Transmit Descriptor Ring Engine

This block feeds a transmit FIFO from frames that host software has placed in memory. Software describes each buffer with a four-word descriptor held in a fixed ring and hands the descriptor over by setting its ownership bit. The engine reads descriptors one at a time over a single-outstanding memory request port. It checks the ownership and segment flags, copies the buffer's words into the FIFO, and returns each descriptor by writing its first word back with ownership cleared.

A frame may span several descriptors. The first carries a start flag and the final one an end flag. Completion can raise a transmit-done status bit. The engine suspends when it meets a descriptor software still owns, when the segment flags do not fit, or when the line side reports an underflow. A suspended engine keeps its ring position and restarts only on a poll-demand strobe. Status bits are sticky and cleared by a write-one-to-clear strobe. Two summary bits and an interrupt line are formed from the enabled members.

Top module: `txr_dma_top`

## Requirements
- R1: Descriptor i sits at word address BASE_ADDR + 4*i. Words 0, 1 and 2 are read in that order. If word 0 bit 31 (ownership) is 0, the engine suspends without reading further, sets status bit 2 and leaves the ring index unchanged.
- R2: Word 1 bit 29 marks the start of a frame. A descriptor read between frames must have it set, and one read inside a frame must have it clear. On a mismatch the engine suspends as in R1, moves no data and writes nothing to memory.
- R3: Word 1 bits 11:0 give the buffer length in 32-bit words and word 2 gives the buffer's word address. That many words are read from consecutive addresses and pushed into the FIFO in address order. If word 1 bit 30 (end of frame) is clear, the next descriptor is fetched and the frame continues.
- R4: After its buffer, each descriptor's word 0 is written back with bit 31 cleared. A middle descriptor is written as 0. The end-of-frame descriptor is written as 1 (bit 0 = completed).
- R5: When the end-of-frame descriptor has word 1 bit 31 set, status bit 0 is set on its write-back. Without bit 31, status bit 0 stays 0.
- R6: A tx_unf pulse during a frame stops the data reads. Word 0 of the current descriptor is then written as 2 (bit 1 = underflow, bit 31 clear), status bits 5 and 15 are set, and the engine suspends with the ring index one past the aborted descriptor.
- R7: The ring index advances by one on each write-back and wraps from 2^RING_LOG2-1 to 0.
- R8: While suspended, only a poll strobe restarts the engine. A poll at any other time has no effect. If a polled descriptor is still software-owned, the engine suspends again.
- R9: Status bits 0, 2 and 5 are sticky. A 1 in sts_clr clears the matching bit.
- R10: Status bit 16 is (bit0 & en[0]) | (bit2 & en[2]) and bit 15 is bit5 & en[5]. irq is (bit16 & en[16]) | (bit15 & en[15]).
- R11: With run low, no new frame starts. The engine issues no memory request between frames, and a frame already under way completes.
- R12: No new buffer read is issued while fifo_full is high.
- R13: Reset leaves all status bits, irq, mem_req, suspended and ring_idx at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| run | input | 1 | Enable for starting new frames |
| poll | input | 1 | Poll-demand strobe that resumes a suspended engine |
| tx_unf | input | 1 | Underflow report from the line side |
| sts_en | input | 17 | Enable mask for summary bits and interrupt |
| sts_clr | input | 17 | Write-one-to-clear strobe for status |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | AW | Word address |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Request completed; read data valid |
| mem_rdata | input | 32 | Read data |
| fifo_wr | output | 1 | Push into transmit FIFO |
| fifo_wdata | output | 32 | Pushed word |
| fifo_full | input | 1 | FIFO cannot take more words |
| sts | output | 17 | Status vector |
| irq | output | 1 | Interrupt |
| suspended | output | 1 | Engine is waiting for a poll |
| ring_idx | output | RING_LOG2 | Current ring position |

## Verification
Single-descriptor frames are swept over buffer lengths 1 to 6 across more than one trip round the ring. This separates length and address errors from wrap errors. A three-descriptor frame shows whether middle and final write-back values and the start/end flag rules are told apart. Further runs cover a descriptor without the interrupt bit, a frame with no start flag, a repeated poll on a still-owned descriptor, an underflow in mid-buffer, run held low, a full FIFO and masked enables. Each of these drives one suspend or gating path while the others stay quiet.

// File: rtl/txr_pkg.sv
package txr_pkg;
    localparam int DW   = 32;
    localparam int STW  = 17;
    localparam int SZ_W = 12;

    // descriptor word 0
    localparam int D0_OWN  = 31;
    localparam int D0_DONE = 0;
    localparam int D0_UNF  = 1;
    // descriptor word 1
    localparam int D1_IC = 31;
    localparam int D1_LS = 30;
    localparam int D1_FS = 29;

    // status positions
    localparam int S_TI  = 0;
    localparam int S_TU  = 2;
    localparam int S_UNF = 5;
    localparam int S_AIS = 15;
    localparam int S_NIS = 16;

    typedef enum logic [2:0] {
        E_IDLE, E_FETCH, E_CHECK, E_DATA, E_WB, E_SUSP
    } eng_st_e;

    typedef struct packed {
        logic ti;
        logic tu;
        logic unf;
    } txr_evt_t;

    function automatic logic is_member(input int pos);
        return (pos == S_TI) || (pos == S_TU) || (pos == S_UNF);
    endfunction
endpackage

// File: rtl/txr_ring_ptr.sv
module txr_ring_ptr #(
    parameter int RING_LOG2 = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 inc,
    output logic [RING_LOG2-1:0] idx
);
    always_ff @(posedge clk) begin
        if (rst)
            idx <= '0;
        else if (inc)
            idx <= idx + 1'b1;
    end

    // R7
    ring_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (inc && (idx == {RING_LOG2{1'b1}})) |=> (idx == '0));
endmodule

// File: rtl/txr_status.sv
module txr_status
    import txr_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    input  txr_evt_t       evt,
    input  logic [STW-1:0] clr,
    input  logic [STW-1:0] en,
    output logic [STW-1:0] sts,
    output logic           irq
);
    logic [STW-1:0] set_v;
    logic [STW-1:0] q;
    logic           nis, ais;

    always_comb begin
        set_v        = '0;
        set_v[S_TI]  = evt.ti;
        set_v[S_TU]  = evt.tu;
        set_v[S_UNF] = evt.unf;
    end

    for (genvar i = 0; i < STW; i++) begin : g_bit
        if (is_member(i)) begin : g_reg
            logic b;
            always_ff @(posedge clk) begin
                if (rst)
                    b <= 1'b0;
                else
                    b <= set_v[i] | (b & ~clr[i]);
            end
            assign q[i] = b;
            // R9
            sticky_hold_chk: assert property (@(posedge clk) disable iff (rst)
                (b && !clr[i]) |=> b);
        end else begin : g_zero
            assign q[i] = 1'b0;
        end
    end

    assign nis = (q[S_TI] & en[S_TI]) | (q[S_TU] & en[S_TU]);
    assign ais = q[S_UNF] & en[S_UNF];

    always_comb begin
        sts        = q;
        sts[S_NIS] = nis;
        sts[S_AIS] = ais;
    end

    assign irq = (nis & en[S_NIS]) | (ais & en[S_AIS]);
endmodule

// File: rtl/txr_engine.sv
module txr_engine
    import txr_pkg::*;
#(
    parameter int              AW        = 10,
    parameter int              RING_LOG2 = 2,
    parameter logic [AW-1:0]   BASE_ADDR = 10'h040
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 run,
    input  logic                 poll,
    input  logic                 tx_unf,
    input  logic [RING_LOG2-1:0] ring_idx,
    output logic                 ptr_inc,
    output txr_evt_t             evt,
    output logic                 suspended,
    output logic                 mem_req,
    output logic                 mem_we,
    output logic [AW-1:0]        mem_addr,
    output logic [DW-1:0]        mem_wdata,
    input  logic                 mem_ack,
    input  logic [DW-1:0]        mem_rdata,
    output logic                 fifo_wr,
    output logic [DW-1:0]        fifo_wdata,
    input  logic                 fifo_full
);
    eng_st_e          st;
    logic [1:0]       widx;
    logic [SZ_W-1:0]  cnt;
    logic [DW-1:0]    d1q, d2q;
    logic             in_frame, unf_pend, abort, pend;
    logic [AW-1:0]    dbase;
    logic [SZ_W-1:0]  len;
    logic             mismatch, do_abort, data_req;

    assign len      = d1q[SZ_W-1:0];
    assign dbase    = BASE_ADDR + AW'({ring_idx, 2'b00});
    assign mismatch = (d1q[D1_FS] == in_frame);
    assign do_abort = (st == E_DATA) && unf_pend && !pend;
    assign data_req = (st == E_DATA) && !(unf_pend && !pend) && (pend || !fifo_full);

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= E_IDLE;
            widx     <= '0;
            cnt      <= '0;
            d1q      <= '0;
            d2q      <= '0;
            in_frame <= 1'b0;
            unf_pend <= 1'b0;
            abort    <= 1'b0;
            pend     <= 1'b0;
        end else begin
            pend <= data_req && !mem_ack;
            if (tx_unf && in_frame)
                unf_pend <= 1'b1;
            case (st)
                E_IDLE: begin
                    if (in_frame || run) begin
                        st   <= E_FETCH;
                        widx <= '0;
                    end
                end
                E_FETCH: begin
                    if (mem_ack) begin
                        case (widx)
                            2'd0: begin
                                if (!mem_rdata[D0_OWN]) st <= E_SUSP;
                                else widx <= 2'd1;
                            end
                            2'd1: begin
                                d1q  <= mem_rdata;
                                widx <= 2'd2;
                            end
                            default: begin
                                d2q <= mem_rdata;
                                st  <= E_CHECK;
                            end
                        endcase
                    end
                end
                E_CHECK: begin
                    if (mismatch) begin
                        st <= E_SUSP;
                    end else begin
                        in_frame <= 1'b1;
                        cnt      <= '0;
                        abort    <= 1'b0;
                        st       <= (len == '0) ? E_WB : E_DATA;
                    end
                end
                E_DATA: begin
                    if (do_abort) begin
                        abort <= 1'b1;
                        st    <= E_WB;
                    end else if (mem_ack) begin
                        cnt <= cnt + 1'b1;
                        if (cnt == len - 1'b1)
                            st <= E_WB;
                    end
                end
                E_WB: begin
                    if (mem_ack) begin
                        st <= abort ? E_SUSP : E_IDLE;
                        if (abort || d1q[D1_LS]) begin
                            in_frame <= 1'b0;
                            unf_pend <= 1'b0;
                        end
                    end
                end
                default: begin
                    if (poll)
                        st <= E_IDLE;
                end
            endcase
        end
    end

    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = dbase;
        mem_wdata = '0;
        case (st)
            E_FETCH: begin
                mem_req  = 1'b1;
                mem_addr = dbase + AW'(widx);
            end
            E_DATA: begin
                mem_req  = data_req;
                mem_addr = d2q[AW-1:0] + AW'(cnt);
            end
            E_WB: begin
                mem_req            = 1'b1;
                mem_we             = 1'b1;
                mem_wdata[D0_UNF]  = abort;
                mem_wdata[D0_DONE] = !abort && d1q[D1_LS];
            end
            default: ;
        endcase
    end

    assign ptr_inc    = (st == E_WB) && mem_ack;
    assign fifo_wr    = (st == E_DATA) && mem_ack;
    assign fifo_wdata = mem_rdata;
    assign suspended  = (st == E_SUSP);

    always_comb begin
        evt.ti  = ptr_inc && !abort && d1q[D1_LS] && d1q[D1_IC];
        evt.unf = ptr_inc && abort;
        evt.tu  = ((st == E_FETCH) && mem_ack && (widx == 2'd0) && !mem_rdata[D0_OWN])
                || ((st == E_CHECK) && mismatch);
    end

    // R4
    wb_own_clr_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_we) |-> !mem_wdata[D0_OWN]);
    // R3
    req_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));
    // R11
    stop_gate_chk: assert property (@(posedge clk) disable iff (rst)
        ((st == E_IDLE) && !in_frame && !run) |=> !mem_req);
    // R8
    susp_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (suspended && !poll) |=> suspended);
    // R12
    full_gate_chk: assert property (@(posedge clk) disable iff (rst)
        ((st == E_DATA) && !pend && fifo_full) |-> !mem_req);
endmodule

// File: rtl/txr_dma_top.sv
module txr_dma_top
    import txr_pkg::*;
#(
    parameter int            AW        = 10,
    parameter int            RING_LOG2 = 2,
    parameter logic [AW-1:0] BASE_ADDR = 10'h040
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 run,
    input  logic                 poll,
    input  logic                 tx_unf,
    input  logic [16:0]          sts_en,
    input  logic [16:0]          sts_clr,
    output logic                 mem_req,
    output logic                 mem_we,
    output logic [AW-1:0]        mem_addr,
    output logic [31:0]          mem_wdata,
    input  logic                 mem_ack,
    input  logic [31:0]          mem_rdata,
    output logic                 fifo_wr,
    output logic [31:0]          fifo_wdata,
    input  logic                 fifo_full,
    output logic [16:0]          sts,
    output logic                 irq,
    output logic                 suspended,
    output logic [RING_LOG2-1:0] ring_idx
);
    txr_evt_t evt;
    logic     ptr_inc;

    txr_ring_ptr #(.RING_LOG2(RING_LOG2)) u_ptr (
        .clk (clk),
        .rst (rst),
        .inc (ptr_inc),
        .idx (ring_idx)
    );

    txr_engine #(
        .AW        (AW),
        .RING_LOG2 (RING_LOG2),
        .BASE_ADDR (BASE_ADDR)
    ) u_eng (
        .clk        (clk),
        .rst        (rst),
        .run        (run),
        .poll       (poll),
        .tx_unf     (tx_unf),
        .ring_idx   (ring_idx),
        .ptr_inc    (ptr_inc),
        .evt        (evt),
        .suspended  (suspended),
        .mem_req    (mem_req),
        .mem_we     (mem_we),
        .mem_addr   (mem_addr),
        .mem_wdata  (mem_wdata),
        .mem_ack    (mem_ack),
        .mem_rdata  (mem_rdata),
        .fifo_wr    (fifo_wr),
        .fifo_wdata (fifo_wdata),
        .fifo_full  (fifo_full)
    );

    txr_status u_sts (
        .clk (clk),
        .rst (rst),
        .evt (evt),
        .clr (sts_clr),
        .en  (sts_en),
        .sts (sts),
        .irq (irq)
    );
endmodule

// File: tb/txr_dma_top_tb_top.sv
`timescale 1ns/1ps
module txr_dma_top_tb_top;
    localparam logic [9:0] BASE = 10'h040;
    localparam logic [31:0] OWN = 32'h8000_0000;
    localparam logic [31:0] IC = 32'h8000_0000;
    localparam logic [31:0] LS = 32'h4000_0000;
    localparam logic [31:0] FS = 32'h2000_0000;

    logic clk = 1'b0, rst = 1'b1, run = 1'b0, poll = 1'b0, tx_unf = 1'b0;
    logic [16:0] sts_en = 17'h1FFFF, sts_clr = '0;
    logic mem_req, mem_we, mem_ack = 1'b0, fifo_wr, fifo_full = 1'b0;
    logic [9:0] mem_addr;
    logic [31:0] mem_wdata, mem_rdata = '0, fifo_wdata;
    logic [16:0] sts;
    logic irq, suspended;
    logic [1:0] ring_idx;

    logic [31:0] mem [0:1023];
    logic [31:0] pushed [0:255];
    int npush = 0, reqcnt = 0, cyc = 0;
    logic hwe = 1'b0;
    logic [9:0] haddr = '0;
    logic [31:0] hdata = '0;
    int nvec = 0, nerr = 0, cur = 0;

    always #10 clk = ~clk;

    txr_dma_top dut_i (
        .clk(clk), .rst(rst), .run(run), .poll(poll), .tx_unf(tx_unf),
        .sts_en(sts_en), .sts_clr(sts_clr), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack),
        .mem_rdata(mem_rdata), .fifo_wr(fifo_wr), .fifo_wdata(fifo_wdata),
        .fifo_full(fifo_full), .sts(sts), .irq(irq), .suspended(suspended),
        .ring_idx(ring_idx)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        mem_ack <= mem_req && !mem_ack && !rst;
        if (mem_req && !mem_ack) begin
            mem_rdata <= (mem_addr >= 10'h200) ? (32'hC0DE_0000 | {22'b0, mem_addr})
                                               : mem[mem_addr];
            if (mem_we) mem[mem_addr] <= mem_wdata;
        end
        if (hwe) mem[haddr] <= hdata;
        if (fifo_wr) begin
            pushed[npush[7:0]] <= fifo_wdata;
            npush <= npush + 1;
        end
        if (mem_req) reqcnt <= reqcnt + 1;
    end

    always @(negedge clk) begin
        if (cyc > 150000) begin
            nerr++;
            $display("FAIL watchdog got %0d exp below 150000", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
            $finish;
        end
    end

    function automatic logic [9:0] da(input int i);
        return BASE + 10'(4 * (i % 4));
    endfunction

    function automatic logic [31:0] pat(input logic [9:0] a);
        return 32'hC0DE_0000 | {22'b0, a};
    endfunction

    task automatic chk(input string rq, input logic [31:0] got, input logic [31:0] exp);
        nvec++;
        if (got !== exp) begin
            nerr++;
            $display("FAIL %s got %h exp %h", rq, got, exp);
        end
    endtask

    task automatic hwr(input logic [9:0] a, input logic [31:0] d);
        @(negedge clk);
        hwe = 1'b1; haddr = a; hdata = d;
        @(negedge clk);
        hwe = 1'b0;
    endtask

    task automatic setd(input int i, input logic [31:0] w0, w1, w2);
        hwr(da(i), w0);
        hwr(da(i) + 10'd1, w1);
        hwr(da(i) + 10'd2, w2);
    endtask

    task automatic wait_susp(input string rq);
        int k;
        k = 0;
        while (!suspended && k < 3000) begin
            @(negedge clk);
            k++;
        end
        chk(rq, {31'b0, suspended}, 32'd1);
    endtask

    task automatic do_poll(input string rq);
        @(negedge clk); poll = 1'b1;
        @(negedge clk); poll = 1'b0;
        wait_susp(rq);
    endtask

    task automatic clr_all;
        @(negedge clk); sts_clr = '1;
        @(negedge clk); sts_clr = '0;
    endtask

    task automatic chk_push(input string rq, input int base, input logic [9:0] ba, input int len);
        for (int k = 0; k < len; k++)
            chk(rq, pushed[(base + k) % 256], pat(ba + 10'(k)));
    endtask

    initial begin
        int np0;
        logic [9:0] ba;
        for (int i = 0; i < 4; i++) setd(i, 32'h0, 32'h0, 32'h0);
        // R13 reset state
        @(negedge clk);
        chk("R13 sts", {15'b0, sts}, 32'h0);
        chk("R13 irq/req/susp", {29'b0, irq, mem_req, suspended}, 32'h0);
        chk("R13 idx", {30'b0, ring_idx}, 32'h0);
        rst = 1'b0;
        @(negedge clk);
        run = 1'b1;
        wait_susp("R1 start suspend");
        chk("R1 tu+nis", {15'b0, sts}, 32'h0001_0004);
        chk("R1 idx", {30'b0, ring_idx}, 32'h0);
        chk("R10 irq", {31'b0, irq}, 32'd1);
        clr_all;
        chk("R9 w1c", {15'b0, sts}, 32'h0);

        // R3/R4/R5/R7 sweep over lengths
        for (int len = 1; len <= 6; len++) begin
            ba = 10'h200 + 10'(len * 16);
            setd(cur, OWN, FS | LS | IC | 32'(len), {22'b0, ba});
            np0 = npush;
            do_poll("R8 poll resume");
            chk("R3 count", npush - np0, len);
            chk_push("R3 data", np0, ba, len);
            chk("R4 last wb", mem[da(cur)], 32'h1);
            cur = (cur + 1) % 4;
            chk("R7 idx", {30'b0, ring_idx}, 32'(cur));
            chk("R5 ti+tu+nis", {15'b0, sts}, 32'h0001_0005);
            clr_all;
        end

        // R3/R4 three-descriptor frame
        setd(cur, OWN, FS | 32'd2, 32'h0000_0280);
        setd(cur + 1, OWN, 32'd3, 32'h0000_0290);
        setd(cur + 2, OWN, LS | IC | 32'd1, 32'h0000_02A0);
        hwr(da(cur + 3), 32'h0);
        np0 = npush;
        do_poll("R3 chain");
        chk("R3 chain count", npush - np0, 6);
        chk_push("R3 seg0", np0, 10'h280, 2);
        chk_push("R3 seg1", np0 + 2, 10'h290, 3);
        chk_push("R3 seg2", np0 + 5, 10'h2A0, 1);
        chk("R4 mid wb0", mem[da(cur)], 32'h0);
        chk("R4 mid wb1", mem[da(cur + 1)], 32'h0);
        chk("R4 end wb", mem[da(cur + 2)], 32'h1);
        cur = (cur + 3) % 4;
        chk("R7 chain idx", {30'b0, ring_idx}, 32'(cur));
        chk("R5 chain ti", {31'b0, sts[0]}, 32'd1);
        clr_all;

        // R5 no interrupt bit
        setd(cur, OWN, FS | LS | 32'd2, 32'h0000_0300);
        do_poll("R5 no ic");
        cur = (cur + 1) % 4;
        chk("R5 no ti", {31'b0, sts[0]}, 32'd0);
        clr_all;

        // R8 poll on still-owned descriptor
        np0 = npush;
        do_poll("R8 repoll");
        chk("R8 no data", npush - np0, 0);
        chk("R8 idx kept", {30'b0, ring_idx}, 32'(cur));
        chk("R8 tu again", {31'b0, sts[2]}, 32'd1);
        clr_all;

        // R2 start flag missing
        setd(cur, OWN, LS | 32'd1, 32'h0000_0310);
        np0 = npush;
        do_poll("R2 fs missing");
        chk("R2 no data", npush - np0, 0);
        chk("R2 desc untouched", mem[da(cur)], OWN);
        chk("R2 idx", {30'b0, ring_idx}, 32'(cur));
        chk("R2 tu", {31'b0, sts[2]}, 32'd1);
        clr_all;
        hwr(da(cur) + 10'd1, FS | LS | 32'd1);
        hwr(da(cur + 1), 32'h0);
        do_poll("R2 fixed");
        cur = (cur + 1) % 4;
        chk("R2 fixed idx", {30'b0, ring_idx}, 32'(cur));
        clr_all;

        // R6 underflow in mid-buffer
        setd(cur, OWN, FS | LS | IC | 32'd12, 32'h0000_0340);
        hwr(da(cur + 1), OWN);
        np0 = npush;
        @(negedge clk); poll = 1'b1;
        @(negedge clk); poll = 1'b0;
        for (int k = 0; k < 500 && (npush - np0) < 3; k++) @(negedge clk);
        tx_unf = 1'b1;
        @(negedge clk); tx_unf = 1'b0;
        wait_susp("R6 suspend");
        chk("R6 wb", mem[da(cur)], 32'h2);
        chk("R6 partial", {31'b0, (npush - np0) < 12}, 32'd1);
        cur = (cur + 1) % 4;
        chk("R6 idx", {30'b0, ring_idx}, 32'(cur));
        chk("R6 status", {15'b0, sts}, 32'h0000_8020);
        chk("R6 irq", {31'b0, irq}, 32'd1);
        clr_all;

        // R11 run low at frame boundary
        setd(cur, OWN, FS | LS | 32'd2, 32'h0000_0360);
        hwr(da(cur + 1), 32'h0);
        run = 1'b0;
        np0 = reqcnt;
        @(negedge clk); poll = 1'b1;
        @(negedge clk); poll = 1'b0;
        repeat (40) @(negedge clk);
        chk("R11 no req", reqcnt - np0, 0);
        chk("R11 not susp", {31'b0, suspended}, 32'd0);
        np0 = npush;
        run = 1'b1;
        wait_susp("R11 resumed");
        chk("R11 data", npush - np0, 2);
        cur = (cur + 1) % 4;
        clr_all;

        // R12 fifo full
        setd(cur, OWN, FS | LS | 32'd3, 32'h0000_0380);
        hwr(da(cur + 1), 32'h0);
        fifo_full = 1'b1;
        np0 = npush;
        @(negedge clk); poll = 1'b1;
        @(negedge clk); poll = 1'b0;
        repeat (40) @(negedge clk);
        chk("R12 stalled", npush - np0, 0);
        fifo_full = 1'b0;
        wait_susp("R12 drain");
        chk_push("R12 data", np0, 10'h380, 3);
        cur = (cur + 1) % 4;
        clr_all;

        // R10 masked enables
        sts_en = 17'h1FFFA;
        setd(cur, OWN, FS | LS | IC | 32'd1, 32'h0000_03A0);
        hwr(da(cur + 1), 32'h0);
        do_poll("R10 masked");
        chk("R10 raw bits", {15'b0, sts}, 32'h0000_0005);
        chk("R10 irq off", {31'b0, irq}, 32'd0);

        $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
        $finish;
    end
endmodule